// File: doc/BRIEF.md
# Serial Tape Line Format Generator

This block produces, one tape line at a time, what a block-structured serial tape would present at a given line position. The line stream has two parts. The first is a timing/mark bit taken from a six-bit code stream. The second is a three-bit data nibble. A requester presents a line position together with a read or write mode. After the block has decoded the position into a zone, it answers with a one-cycle result strobe. When the position falls inside the block area, the decode also gives a block number and a line offset within that block.

The tape is laid out in this order: a reverse end zone, then a reverse gap of interblock codes, then the blocks, then a forward gap, then a forward end zone. Each block holds three parts: a 30-line header, then 129 twelve-bit data words of four lines each, then a 30-line trailer. Header and trailer nibbles are synthesized from two things: the block number and a folded XOR checksum of the block's data. The block has two external word-read ports. Data-word nibbles come from the line read port. The checksum is built by a background pass over the block's words on the second port. In write mode, the block issues a nibble write strobe for data lines only, and it discards every header and trailer nibble.

Top module: `tape_fmt_gen`

## Requirements
- R1: Outside the block area the mark bit is bit (5 - pos mod 6) of a six-bit zone code, most significant bit first. The codes are 055 (octal) for positions below 47952, 025 for 47952..49151, 025 for 898176..899375, and 022 from 899376 up.
- R2: For a position p in 49152..898175, the block number is (p-49152)/576 and the offset is (p-49152) mod 576. The mark code index offset/6 selects, in order: 025, 026, 032, 010 four times, 070 for indices 7..88, 073 for indices 89..92, then 051, 045 and 025.
- R3: In read mode, header offsets 8, 9, 10 and 11 give block-number bits [11:9], [8:6], [5:3] and [2:0]. Offsets 24..29 give 7. All other header offsets give 0.
- R4: In read mode, data offset d = offset-30 (in 0..515) reads word address block*129 + d/4 on the line read port. It returns bits [11:9], [8:6], [5:3] and [2:0] of that word for d mod 4 = 0, 1, 2 and 3.
- R5: The checksum starts at 07777 and is XORed with the complement of each of the block's 129 words. It is then folded to six bits as upper half XOR lower half. In read mode, trailer offset t = offset-546 gives checksum bits [5:3] at t=0 and bits [2:0] at t=1.
- R6: In read mode, trailer offsets t = 18, 19, 20 and 21 give the complement of block-number bits [2:0], [5:3], [8:6] and [11:9]. All other trailer offsets except 0 and 1 give 0.
- R7: In write mode the nibble output is 0 on every line, while the mark bit still follows R1/R2. A data line raises the write strobe with three values: the word address from R4, a nibble select equal to d mod 4 (0 = bits [11:9]), and the requested nibble. Header and trailer lines raise no write strobe.
- R8: A request is answered by a one-cycle result strobe on the second clock edge after it. The exception is a read-mode trailer checksum line whose checksum pass has not yet finished. Any read-mode line of a block starts that block's pass. A request is made only after the previous result.
- R9: After reset the result strobe, mark bit, nibble and write strobe are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| lineReq | input | 1 | One-cycle request for a line |
| linePos | input | 20 | Absolute line position |
| writeMode | input | 1 | 1 = write mode, 0 = read mode |
| wrData | input | 3 | Nibble to write on a data line |
| rdAddr | output | 18 | Word address for a data-line read |
| rdData | input | 12 | Word at rdAddr, same cycle |
| sumAddr | output | 18 | Word address for the checksum pass |
| sumData | input | 12 | Word at sumAddr, same cycle |
| outValid | output | 1 | Result strobe |
| markBit | output | 1 | Mark-track bit of the line |
| dataNib | output | 3 | Data nibble of the line |
| wrEn | output | 1 | Nibble write strobe |
| wrAddr | output | 18 | Word address of the write |
| wrNibSel | output | 2 | Nibble position within the word |
| wrNib | output | 3 | Nibble value to write |

## Verification
The stimulus covers every zone and every part of a block. It walks runs of six consecutive lines in each end zone and each gap, including the last line of the reverse end zone and the very last line of the tape, so the tests can catch an off-by-one zone boundary or a reversed bit order. Inside a block, it walks every header line and every trailer line of a high-numbered block, and it reads the mark code at each change in the in-block sequence, which catches a wrong code order or length. Data lines are read against a hashed word memory, and trailer checksums are compared with a model sum. One trailer is reached sequentially and another is reached by jumping straight to it, so the tests can tell apart a pass started early from one forced to stall. The same lines are then repeated in write mode, which separates nibble suppression from write-strobe generation.

// File: rtl/tfg_pkg.sv
package tfg_pkg;
  localparam int LINES_PER_CODE = 6;
  localparam int HDR_LINES      = 30;
  localparam int WORD_LINES     = 4;
  localparam int WORD_W         = 12;
  localparam int SUM_W          = 6;

  localparam logic [5:0] CODE_REV_END = 6'o55;
  localparam logic [5:0] CODE_GAP     = 6'o25;
  localparam logic [5:0] CODE_BLK_FWD = 6'o26;
  localparam logic [5:0] CODE_GUARD_R = 6'o32;
  localparam logic [5:0] CODE_LEAD    = 6'o10;
  localparam logic [5:0] CODE_DATA    = 6'o70;
  localparam logic [5:0] CODE_TAIL    = 6'o73;
  localparam logic [5:0] CODE_GUARD_F = 6'o51;
  localparam logic [5:0] CODE_BLK_REV = 6'o45;
  localparam logic [5:0] CODE_FWD_END = 6'o22;

  typedef enum logic [2:0] {
    ZN_REV_END, ZN_REV_GAP, ZN_BLOCK, ZN_FWD_GAP, ZN_FWD_END
  } zone_e;

  typedef enum logic [1:0] {ST_IDLE, ST_EVAL, ST_WAIT} ctrlState_e;

  typedef struct packed {
    logic capture;
    logic emit;
    logic sumStart;
  } strobe_t;
endpackage

// File: rtl/tfg_mark.sv
module tfg_mark import tfg_pkg::*; #(
  parameter int CIDX_W     = 7,
  parameter int DATA_CODES = 86,
  parameter int BLK_CODES  = 96
) (
  input  zone_e             zone,
  input  logic [CIDX_W-1:0] codeIdx,
  input  logic [2:0]        bitIdx,
  output logic              markNext
);
  localparam logic [CIDX_W-1:0] I_LEAD0  = CIDX_W'(3);
  localparam logic [CIDX_W-1:0] I_DATA0  = CIDX_W'(7);
  localparam logic [CIDX_W-1:0] I_TAIL0  = CIDX_W'(3 + DATA_CODES);
  localparam logic [CIDX_W-1:0] I_GUARDF = CIDX_W'(BLK_CODES - 3);
  localparam logic [CIDX_W-1:0] I_BLKREV = CIDX_W'(BLK_CODES - 2);

  logic [5:0] blkCode;
  logic [5:0] code;

  always_comb begin
    if (codeIdx == '0)                blkCode = CODE_GAP;
    else if (codeIdx == CIDX_W'(1))   blkCode = CODE_BLK_FWD;
    else if (codeIdx == CIDX_W'(2))   blkCode = CODE_GUARD_R;
    else if (codeIdx < I_DATA0)       blkCode = CODE_LEAD;
    else if (codeIdx < I_TAIL0)       blkCode = CODE_DATA;
    else if (codeIdx < I_GUARDF)      blkCode = CODE_TAIL;
    else if (codeIdx == I_GUARDF)     blkCode = CODE_GUARD_F;
    else if (codeIdx == I_BLKREV)     blkCode = CODE_BLK_REV;
    else                              blkCode = CODE_GAP;
  end

  always_comb begin
    unique case (zone)
      ZN_REV_END: code = CODE_REV_END;
      ZN_REV_GAP: code = CODE_GAP;
      ZN_BLOCK:   code = blkCode;
      ZN_FWD_GAP: code = CODE_GAP;
      default:    code = CODE_FWD_END;
    endcase
  end

  assign markNext = code[3'd5 - bitIdx];

  always_comb begin
    if (zone == ZN_BLOCK && codeIdx >= I_LEAD0 && codeIdx < I_DATA0)
      assert (blkCode == CODE_LEAD) else $error("AST_LEAD_RUN"); // R2
  end
endmodule

// File: rtl/tfg_ctrl.sv
module tfg_ctrl import tfg_pkg::*; (
  input  logic    clk,
  input  logic    rstN,
  input  logic    lineReq,
  input  logic    needSum,
  input  logic    sumOk,
  input  logic    wantStart,
  input  logic    sumBusy,
  output strobe_t stb
);
  ctrlState_e state, stateNext;

  always_comb begin
    stb       = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: if (lineReq) begin
        stb.capture = 1'b1;
        stateNext   = ST_EVAL;
      end
      ST_EVAL: begin
        stb.sumStart = wantStart;
        if (needSum && !sumOk) stateNext = ST_WAIT;
        else begin
          stb.emit  = 1'b1;
          stateNext = ST_IDLE;
        end
      end
      ST_WAIT: if (sumOk) begin
        stb.emit  = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  AST_REQ_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    lineReq |-> state == ST_IDLE); // R8
  AST_WAIT_HAS_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && !sumOk) |-> sumBusy); // R8
endmodule

// File: rtl/tfg_csum.sv
module tfg_csum import tfg_pkg::*; #(
  parameter int BLK_W      = 11,
  parameter int ADDR_W     = 18,
  parameter int WCNT_W     = 8,
  parameter int DATA_WORDS = 129
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [BLK_W-1:0]  startBlk,
  input  logic [WORD_W-1:0] sumData,
  output logic [ADDR_W-1:0] sumAddr,
  output logic              busy,
  output logic              tgtValid,
  output logic [BLK_W-1:0]  tgtBlk,
  output logic [SUM_W-1:0]  sumVal
);
  localparam logic [WCNT_W-1:0] LAST_W = WCNT_W'(DATA_WORDS - 1);

  logic [WCNT_W-1:0] cnt;
  logic [WORD_W-1:0] acc, accNext;

  assign accNext = acc ^ ~sumData;
  assign sumAddr = ADDR_W'(tgtBlk) * ADDR_W'(DATA_WORDS) + ADDR_W'(cnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0; tgtValid <= 1'b0; tgtBlk <= '0;
      cnt <= '0; acc <= '0; sumVal <= '0;
    end else if (start) begin
      busy <= 1'b1; tgtValid <= 1'b1; tgtBlk <= startBlk;
      cnt <= '0; acc <= '1;
    end else if (busy) begin
      acc <= accNext;
      cnt <= cnt + 1'b1;
      if (cnt == LAST_W) begin
        busy   <= 1'b0;
        sumVal <= accNext[11:6] ^ accNext[5:0];
      end
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> cnt <= LAST_W); // R5
  AST_PASS_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && !$past(start)) |-> $past(cnt) == LAST_W); // R5
endmodule

// File: rtl/tfg_dpath.sv
module tfg_dpath import tfg_pkg::*; #(
  parameter int POS_W       = 20,
  parameter int BLK_W       = 11,
  parameter int ADDR_W      = 18,
  parameter int OFF_W       = 10,
  parameter int CIDX_W      = 7,
  parameter int WCNT_W      = 8,
  parameter int DATA_WORDS  = 129,
  parameter int DATA_LINES  = 516,
  parameter int BLK_LINES   = 576,
  parameter int REV_END_TOP = 47952,
  parameter int DATA_START  = 49152,
  parameter int DATA_END    = 898176,
  parameter int FWD_GAP_TOP = 899376
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [POS_W-1:0]  linePos,
  input  logic              writeMode,
  input  logic [2:0]        wrData,
  input  logic [WORD_W-1:0] rdData,
  input  logic              markNext,
  input  logic              tgtValid,
  input  logic [BLK_W-1:0]  tgtBlk,
  input  logic              sumBusy,
  input  logic [SUM_W-1:0]  sumVal,
  output logic [ADDR_W-1:0] rdAddr,
  output zone_e             zone,
  output logic [CIDX_W-1:0] codeIdx,
  output logic [2:0]        bitIdx,
  output logic [BLK_W-1:0]  blk,
  output logic              needSum,
  output logic              wantStart,
  output logic              sumOk,
  output logic              outValid,
  output logic              markBit,
  output logic [2:0]        dataNib,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [1:0]        wrNibSel,
  output logic [2:0]        wrNib
);
  localparam logic [POS_W-1:0] P_REV_END = POS_W'(REV_END_TOP);
  localparam logic [POS_W-1:0] P_DSTART  = POS_W'(DATA_START);
  localparam logic [POS_W-1:0] P_DEND    = POS_W'(DATA_END);
  localparam logic [POS_W-1:0] P_FWD_GAP = POS_W'(FWD_GAP_TOP);
  localparam logic [POS_W-1:0] P_BLKL    = POS_W'(BLK_LINES);
  localparam logic [POS_W-1:0] P_SIX     = POS_W'(LINES_PER_CODE);
  localparam logic [OFF_W-1:0] O_HDR     = OFF_W'(HDR_LINES);
  localparam logic [OFF_W-1:0] O_TRL     = OFF_W'(HDR_LINES + DATA_LINES);
  localparam logic [OFF_W-1:0] O_SIX     = OFF_W'(LINES_PER_CODE);

  logic [POS_W-1:0] posQ, relPos;
  logic             wrQ;
  logic [2:0]       wdQ;
  logic [OFF_W-1:0] off, dOff, tOff;
  logic [WCNT_W-1:0] wordIdx;
  logic [1:0]       nibSel;
  logic [11:0]      blk12;
  logic             inHdr, inData, inTrl;
  logic [2:0]       hdrNib, datNib, trlNib, nibNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      posQ <= '0; wrQ <= 1'b0; wdQ <= '0;
    end else if (stb.capture) begin
      posQ <= linePos; wrQ <= writeMode; wdQ <= wrData;
    end
  end

  // position decode
  always_comb begin
    if (posQ < P_REV_END)      zone = ZN_REV_END;
    else if (posQ < P_DSTART)  zone = ZN_REV_GAP;
    else if (posQ < P_DEND)    zone = ZN_BLOCK;
    else if (posQ < P_FWD_GAP) zone = ZN_FWD_GAP;
    else                       zone = ZN_FWD_END;
  end

  assign relPos  = posQ - P_DSTART;
  assign blk     = BLK_W'(relPos / P_BLKL);
  assign off     = OFF_W'(relPos % P_BLKL);
  assign codeIdx = CIDX_W'(off / O_SIX);
  assign bitIdx  = 3'(posQ % P_SIX);
  assign blk12   = 12'(blk);

  assign inHdr   = off < O_HDR;
  assign inData  = !inHdr && off < O_TRL;
  assign inTrl   = !inHdr && !inData;
  assign dOff    = off - O_HDR;
  assign tOff    = off - O_TRL;
  assign wordIdx = WCNT_W'(dOff >> 2);
  assign nibSel  = dOff[1:0];
  assign rdAddr  = ADDR_W'(blk) * ADDR_W'(DATA_WORDS) + ADDR_W'(wordIdx);

  // synthesized header nibble
  always_comb begin
    hdrNib = 3'd0;
    if (off == OFF_W'(8))       hdrNib = blk12[11:9];
    else if (off == OFF_W'(9))  hdrNib = blk12[8:6];
    else if (off == OFF_W'(10)) hdrNib = blk12[5:3];
    else if (off == OFF_W'(11)) hdrNib = blk12[2:0];
    else if (off >= OFF_W'(24)) hdrNib = 3'd7;
  end

  // data word nibble, upper first
  always_comb begin
    unique case (nibSel)
      2'd0: datNib = rdData[11:9];
      2'd1: datNib = rdData[8:6];
      2'd2: datNib = rdData[5:3];
      default: datNib = rdData[2:0];
    endcase
  end

  // synthesized trailer nibble
  always_comb begin
    trlNib = 3'd0;
    if (tOff == '0)                trlNib = sumVal[5:3];
    else if (tOff == OFF_W'(1))    trlNib = sumVal[2:0];
    else if (tOff == OFF_W'(18))   trlNib = ~blk12[2:0];
    else if (tOff == OFF_W'(19))   trlNib = ~blk12[5:3];
    else if (tOff == OFF_W'(20))   trlNib = ~blk12[8:6];
    else if (tOff == OFF_W'(21))   trlNib = ~blk12[11:9];
  end

  always_comb begin
    nibNext = 3'd0;
    if (zone == ZN_BLOCK && !wrQ) begin
      if (inHdr)       nibNext = hdrNib;
      else if (inData) nibNext = datNib;
      else             nibNext = trlNib;
    end
  end

  assign sumOk     = tgtValid && !sumBusy && tgtBlk == blk;
  assign wantStart = !wrQ && zone == ZN_BLOCK && !(tgtValid && tgtBlk == blk);
  assign needSum   = !wrQ && zone == ZN_BLOCK && inTrl && tOff < OFF_W'(2);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0; markBit <= 1'b0; dataNib <= '0;
      wrEn <= 1'b0; wrAddr <= '0; wrNibSel <= '0; wrNib <= '0;
    end else begin
      outValid <= stb.emit;
      wrEn     <= stb.emit && wrQ && zone == ZN_BLOCK && inData;
      if (stb.emit) begin
        markBit  <= markNext;
        dataNib  <= nibNext;
        wrAddr   <= rdAddr;
        wrNibSel <= nibSel;
        wrNib    <= wdQ;
      end
    end
  end

  AST_WR_NIB_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> dataNib == 3'd0); // R7
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid); // R8
  AST_EMIT_HAS_SUM: assert property (@(posedge clk) disable iff (!rstN)
    (stb.emit && needSum) |-> sumOk); // R5
endmodule

// File: rtl/tape_fmt_gen.sv
module tape_fmt_gen import tfg_pkg::*; #(
  parameter int BLOCKS     = 1474,
  parameter int DATA_WORDS = 129,
  parameter int END_CODES  = 8192,
  parameter int GAP_CODES  = 200,
  localparam int DATA_LINES  = DATA_WORDS * WORD_LINES,
  localparam int BLK_LINES   = 2 * HDR_LINES + DATA_LINES,
  localparam int BLK_CODES   = BLK_LINES / LINES_PER_CODE,
  localparam int DATA_CODES  = DATA_LINES / LINES_PER_CODE,
  localparam int END_LINES   = END_CODES * LINES_PER_CODE,
  localparam int GAP_LINES   = GAP_CODES * LINES_PER_CODE,
  localparam int DATA_START  = END_LINES,
  localparam int DATA_END    = DATA_START + BLOCKS * BLK_LINES,
  localparam int TOTAL_LINES = DATA_END + END_LINES,
  localparam int POS_W       = $clog2(TOTAL_LINES),
  localparam int ADDR_W      = $clog2(BLOCKS * DATA_WORDS),
  localparam int BLK_W       = $clog2(BLOCKS),
  localparam int OFF_W       = $clog2(BLK_LINES),
  localparam int CIDX_W      = $clog2(BLK_CODES),
  localparam int WCNT_W      = $clog2(DATA_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineReq,
  input  logic [POS_W-1:0]  linePos,
  input  logic              writeMode,
  input  logic [2:0]        wrData,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [11:0]       rdData,
  output logic [ADDR_W-1:0] sumAddr,
  input  logic [11:0]       sumData,
  output logic              outValid,
  output logic              markBit,
  output logic [2:0]        dataNib,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [1:0]        wrNibSel,
  output logic [2:0]        wrNib
);
  strobe_t           stb;
  zone_e             zone;
  logic [CIDX_W-1:0] codeIdx;
  logic [2:0]        bitIdx;
  logic [BLK_W-1:0]  blk, tgtBlk;
  logic              needSum, wantStart, sumOk, sumBusy, tgtValid, markNext;
  logic [SUM_W-1:0]  sumVal;

  tfg_ctrl u_ctrl (
    .clk, .rstN, .lineReq, .needSum, .sumOk, .wantStart,
    .sumBusy, .stb
  );

  tfg_mark #(.CIDX_W(CIDX_W), .DATA_CODES(DATA_CODES), .BLK_CODES(BLK_CODES)) u_mark (
    .zone, .codeIdx, .bitIdx, .markNext
  );

  tfg_csum #(.BLK_W(BLK_W), .ADDR_W(ADDR_W), .WCNT_W(WCNT_W), .DATA_WORDS(DATA_WORDS)) u_csum (
    .clk, .rstN, .start(stb.sumStart), .startBlk(blk), .sumData,
    .sumAddr, .busy(sumBusy), .tgtValid, .tgtBlk, .sumVal
  );

  tfg_dpath #(
    .POS_W(POS_W), .BLK_W(BLK_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W),
    .CIDX_W(CIDX_W), .WCNT_W(WCNT_W), .DATA_WORDS(DATA_WORDS),
    .DATA_LINES(DATA_LINES), .BLK_LINES(BLK_LINES),
    .REV_END_TOP(END_LINES - GAP_LINES), .DATA_START(DATA_START),
    .DATA_END(DATA_END), .FWD_GAP_TOP(DATA_END + GAP_LINES)
  ) u_dpath (
    .clk, .rstN, .stb, .linePos, .writeMode, .wrData, .rdData,
    .markNext, .tgtValid, .tgtBlk, .sumBusy, .sumVal,
    .rdAddr, .zone, .codeIdx, .bitIdx, .blk, .needSum, .wantStart, .sumOk,
    .outValid, .markBit, .dataNib, .wrEn, .wrAddr, .wrNibSel, .wrNib
  );
endmodule

// File: tb/tape_fmt_gen_bench.sv
`timescale 1ns/1ps
module tape_fmt_gen_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lineReq = 1'b0;
  logic [19:0] linePos = '0;
  logic        writeMode = 1'b0;
  logic [2:0]  wrData = '0;
  logic [17:0] rdAddr, sumAddr, wrAddr;
  logic [11:0] rdData, sumData;
  logic        outValid, markBit, wrEn;
  logic [2:0]  dataNib, wrNib;
  logic [1:0]  wrNibSel;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  function automatic logic [11:0] memWord(input int a);
    return 12'((a * 40503) ^ (a >> 5));
  endfunction

  assign rdData  = memWord(int'(rdAddr));
  assign sumData = memWord(int'(sumAddr));

  tape_fmt_gen u_tape_fmt_gen (
    .clk, .rstN, .lineReq, .linePos, .writeMode, .wrData,
    .rdAddr, .rdData, .sumAddr, .sumData,
    .outValid, .markBit, .dataNib, .wrEn, .wrAddr, .wrNibSel, .wrNib
  );

  typedef struct {
    string      tag;
    int         pos;
    bit         mk;
    logic [2:0] nib;
    bit         we;
    int         addr;
    logic [1:0] sel;
    logic [2:0] wn;
  } exp_t;
  exp_t sbq[$];

  function automatic bit expMark(input int p);
    logic [5:0] c;
    int idx;
    if (p < 47952)       c = 6'o55;
    else if (p < 49152)  c = 6'o25;
    else if (p < 898176) begin
      idx = ((p - 49152) % 576) / 6;
      if (idx == 0)       c = 6'o25;
      else if (idx == 1)  c = 6'o26;
      else if (idx == 2)  c = 6'o32;
      else if (idx <= 6)  c = 6'o10;
      else if (idx <= 88) c = 6'o70;
      else if (idx <= 92) c = 6'o73;
      else if (idx == 93) c = 6'o51;
      else if (idx == 94) c = 6'o45;
      else                c = 6'o25;
    end
    else if (p < 899376) c = 6'o25;
    else                 c = 6'o22;
    return c[5 - (p % 6)];
  endfunction

  function automatic logic [5:0] expSum(input int b);
    logic [11:0] c = 12'o7777;
    for (int w = 0; w < 129; w++) c = c ^ ~memWord(b * 129 + w);
    return c[11:6] ^ c[5:0];
  endfunction

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // driver: pushes the expected result, issues the request, times the answer
  task automatic runLine(input int p, input bit wr, input logic [2:0] wd,
                         input string tag, input int expLat);
    exp_t e;
    int blk, off, d, t, lat;
    logic [5:0] s;
    e.tag = tag; e.pos = p; e.mk = expMark(p); e.nib = 3'd0;
    e.we = 1'b0; e.addr = 0; e.sel = 2'd0; e.wn = 3'd0;
    if (p >= 49152 && p < 898176) begin
      blk = (p - 49152) / 576;
      off = (p - 49152) % 576;
      if (off < 30) begin
        if (!wr) begin
          if (off >= 8 && off <= 11) e.nib = 3'((blk >> (3 * (11 - off))) & 7);
          else if (off >= 24)        e.nib = 3'd7;
        end
      end else if (off < 546) begin
        d = off - 30;
        if (wr) begin
          e.we = 1'b1; e.addr = blk * 129 + d / 4; e.sel = 2'(d % 4); e.wn = wd;
        end else
          e.nib = 3'((memWord(blk * 129 + d / 4) >> (3 * (3 - d % 4))) & 7);
      end else if (!wr) begin
        t = off - 546;
        s = expSum(blk);
        if (t == 0)                 e.nib = s[5:3];
        else if (t == 1)            e.nib = s[2:0];
        else if (t >= 18 && t <= 21) e.nib = 3'((((blk >> (3 * (t - 18))) & 7)) ^ 7);
      end
    end
    sbq.push_back(e);
    @(negedge clk);
    lineReq = 1'b1; linePos = 20'(p); writeMode = wr; wrData = wd;
    lat = 0;
    do begin
      @(posedge clk); #1;
      lineReq = 1'b0;
      lat++;
    end while (!outValid);
    if (expLat != 0) begin
      checks++;
      if ((expLat == 2 && lat != 2) || (expLat == 9 && lat <= 2)) begin
        errors++;
        $display("FAIL R8 %s pos=%0d latency actual=%0d expected=%0d", tag, p, lat, expLat);
      end
    end
    @(negedge clk);
  endtask

  // monitor: compares each answer with the queued expectation
  always @(negedge clk) begin
    exp_t e;
    if (rstN && outValid) begin
      checks++;
      if (sbq.size() == 0) begin
        errors++;
        $display("FAIL R8 unexpected result actual=1 expected=0");
      end else begin
        e = sbq.pop_front();
        if (markBit !== e.mk || dataNib !== e.nib || wrEn !== e.we ||
            (e.we && (int'(wrAddr) != e.addr || wrNibSel !== e.sel || wrNib !== e.wn))) begin
          errors++;
          $display("FAIL %s pos=%0d actual mk=%0b nib=%0o we=%0b addr=%0d sel=%0d wn=%0o expected mk=%0b nib=%0o we=%0b addr=%0d sel=%0d wn=%0o",
                   e.tag, e.pos, markBit, dataNib, wrEn, wrAddr, wrNibSel, wrNib,
                   e.mk, e.nib, e.we, e.addr, e.sel, e.wn);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog actual=running expected=done");
    finishRun();
  end

  localparam int B1234 = 49152 + 1234 * 576;
  localparam int B7    = 49152 + 7 * 576;
  localparam int BLAST = 49152 + 1473 * 576;

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || markBit !== 1'b0 || dataNib !== 3'd0 || wrEn !== 1'b0) begin
      errors++;
      $display("FAIL R9 reset actual=%0b%0b%0o%0b expected=0000", outValid, markBit, dataNib, wrEn);
    end
    rstN = 1'b1;
    @(negedge clk);

    // R1 zones outside the block area
    for (int i = 0; i < 6; i++) runLine(i, 1'b0, 3'd0, "R1 rev end", 2);
    runLine(47951, 1'b0, 3'd0, "R1 rev end last", 2);
    for (int i = 0; i < 6; i++) runLine(47952 + i, 1'b0, 3'd0, "R1 rev gap", 2);
    for (int i = 0; i < 6; i++) runLine(898176 + i, 1'b0, 3'd0, "R1 fwd gap", 2);
    for (int i = 0; i < 6; i++) runLine(899376 + i, 1'b0, 3'd0, "R1 fwd end", 2);
    runLine(947327, 1'b0, 3'd0, "R1 tape end", 2);

    // R2 in-block code sequence on block 0
    for (int i = 0; i < 24; i++) runLine(49152 + i, 1'b0, 3'd0, "R2 block0 codes", 2);

    // R3 header, R2 codes, R4 data, R5/R6 trailer on a high block
    for (int i = 0; i < 30; i++) runLine(B1234 + i, 1'b0, 3'd0, "R3 header", 2);
    for (int i = 30; i < 38; i++) runLine(B1234 + i, 1'b0, 3'd0, "R4 data", 2);
    for (int i = 0; i < 6; i++) begin
      runLine(B1234 + 6 * 7 + i,  1'b0, 3'd0, "R2 first data code", 2);
      runLine(B1234 + 6 * 88 + i, 1'b0, 3'd0, "R2 last data code", 2);
      runLine(B1234 + 6 * 89 + i, 1'b0, 3'd0, "R2 tail code", 2);
      runLine(B1234 + 6 * 93 + i, 1'b0, 3'd0, "R2 fwd guard", 2);
      runLine(B1234 + 6 * 94 + i, 1'b0, 3'd0, "R2 rev block", 2);
      runLine(B1234 + 6 * 95 + i, 1'b0, 3'd0, "R2 closing gap", 2);
    end
    runLine(B1234 + 545, 1'b0, 3'd0, "R4 last data line", 2);
    runLine(B1234 + 546, 1'b0, 3'd0, "R5 sum high early pass", 2);
    runLine(B1234 + 547, 1'b0, 3'd0, "R5 sum low", 2);
    for (int i = 548; i < 576; i++) runLine(B1234 + i, 1'b0, 3'd0, "R6 trailer", 2);

    // R8 jump straight to a trailer: the pass must stall the answer
    runLine(B7 + 546, 1'b0, 3'd0, "R5 sum high stalled", 9);
    runLine(B7 + 547, 1'b0, 3'd0, "R5 sum low after pass", 2);
    runLine(B7 + 564, 1'b0, 3'd0, "R6 trailer blk7", 2);

    // last block
    runLine(BLAST + 9, 1'b0, 3'd0, "R3 last block header", 2);
    runLine(BLAST + 545, 1'b0, 3'd0, "R4 last block data", 2);
    for (int i = 564; i < 568; i++) runLine(BLAST + i, 1'b0, 3'd0, "R6 last block trailer", 2);
    runLine(BLAST + 546, 1'b0, 3'd0, "R5 last block sum", 0);

    // R7 write mode
    runLine(B1234 + 8,   1'b1, 3'd6, "R7 header quiet", 2);
    runLine(B1234 + 26,  1'b1, 3'd6, "R7 header quiet", 2);
    runLine(B1234 + 30,  1'b1, 3'd5, "R7 write sel0", 2);
    runLine(B1234 + 31,  1'b1, 3'd2, "R7 write sel1", 2);
    runLine(B1234 + 32,  1'b1, 3'd7, "R7 write sel2", 2);
    runLine(B1234 + 33,  1'b1, 3'd1, "R7 write sel3", 2);
    runLine(B1234 + 545, 1'b1, 3'd3, "R7 write last word", 2);
    runLine(B7 + 546,    1'b1, 3'd4, "R7 trailer quiet", 2);
    runLine(B7 + 564,    1'b1, 3'd4, "R7 trailer quiet", 2);
    runLine(100,         1'b1, 3'd4, "R7 zone write", 2);

    repeat (4) @(negedge clk);
    checks++;
    if (sbq.size() != 0) begin
      errors++;
      $display("FAIL R8 missing results actual=%0d expected=0", sbq.size());
    end
    finishRun();
  end
endmodule